// File: doc/BRIEF.md
# Shared-Adder Operand Router

This block lets one ripple-carry adder serve ten arithmetic commands of a small ALU. It takes two data words and a one-hot command vector. A small controller turns the command into five control lines. A swap stage puts either operand on either of two lanes. The first adder port carries lane 1, all zeros or all ones. The second adder port carries lane 2, either true or inverted. A carry-in completes the operation. No command ever needs a second adder.

The block registers three results: the sum, the carry into the most significant bit stage (used by the overflow logic outside the block) and the final carry-out. Result selection and flag generation live outside the block. The command vector holds at most one set bit. Bit position n stands for opcode n.

Top module: `addfe_shared_adder`

## Requirements
- R1: While `rst` is high at a rising clock edge, all three outputs are 0 after that edge, whatever the other inputs are.
- R2: Command bit 7 gives A + B + 0. Bit 0 gives 0 + A + 0, so the sum is A. Bit 3 gives 0 + B + 0, so the sum is B.
- R3: Command bit 2 gives A + ~B + 1, so the sum is A − B. Bit 14 gives 0 + ~B + 1, so the sum is −B. Bit 15 gives 0 + ~A + 1, so the sum is −A.
- R4: Command bit 4 gives 0 + A + 1, so the sum is A + 1. Bit 6 gives 0 + B + 1, so the sum is B + 1.
- R5: Command bit 5 gives all-ones + A + 0, so the sum is A − 1. Bit 8 gives all-ones + B + 0, so the sum is B − 1.
- R6: `cout_q` is bit W of (first port + second port + carry-in) for the port values named in R2 to R5 and R8.
- R7: `cmsb_q` is the carry out of the low W−1 bits, that is bit W−1 of (low W−1 bits of each port + carry-in).
- R8: An all-zero command, or any command bit not named in R2 to R5, gives 0 + B + 0.
- R9: Each output shows, one clock edge later, the inputs present at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | W | Operand A |
| b_in | input | W | Operand B |
| cmd_1h | input | 16 | One-hot command; bit n means opcode n |
| sum_q | output | W | Registered adder sum |
| cmsb_q | output | 1 | Registered carry into the MSB stage |
| cout_q | output | 1 | Registered final carry-out |

## Verification
The bench sweeps all 256 operand pairs under each of the ten arithmetic commands. It checks the sum, the carry into the MSB and the carry-out against values built from the port forms in the requirements.

- The full sweep shows a swapped lane: under command 0 or 4, a B-for-A exchange changes the sum whenever A and B differ.
- It shows a stuck inversion: the negate commands under a bad inversion give a result that is off by one or has the wrong sign.
- It shows a wrong carry-in, because the same adder inputs with a different carry-in give different results.

Further vectors drive an all-zero command and a logic-only command to show the default path to B. A reset vector driven with non-zero inputs shows the clear.

// File: rtl/addfe_pkg.sv
package addfe_pkg;
  localparam int CMD_W = 16;

  localparam int OP_PASS_A = 0;
  localparam int OP_SUB    = 2;
  localparam int OP_PASS_B = 3;
  localparam int OP_INC_A  = 4;
  localparam int OP_DEC_A  = 5;
  localparam int OP_INC_B  = 6;
  localparam int OP_ADD    = 7;
  localparam int OP_DEC_B  = 8;
  localparam int OP_NEG_B  = 14;
  localparam int OP_NEG_A  = 15;

  typedef struct packed {
    logic straight;  // 1: A on lane 1, B on lane 2
    logic keep_l1;   // first port takes lane 1
    logic ones;      // first port forced to all ones
    logic pass;      // 1: second port true, 0: inverted
    logic cin;       // adder carry-in
  } addfe_ctl_t;
endpackage

// File: rtl/addfe_ctl.sv
module addfe_ctl
  import addfe_pkg::*;
(
  input  logic [CMD_W-1:0] cmd_1h,
  output addfe_ctl_t       ctl
);
  logic unused_cmd;
  assign unused_cmd = &{1'b0, cmd_1h[1], cmd_1h[OP_PASS_B], cmd_1h[13:9]};

  always_comb begin
    ctl.straight = ~(cmd_1h[OP_PASS_A] | cmd_1h[OP_INC_A] |
                     cmd_1h[OP_DEC_A]  | cmd_1h[OP_NEG_A]);
    ctl.keep_l1  = cmd_1h[OP_SUB] | cmd_1h[OP_ADD];
    ctl.ones     = cmd_1h[OP_DEC_A] | cmd_1h[OP_DEC_B];
    ctl.pass     = ~(cmd_1h[OP_SUB] | cmd_1h[OP_NEG_B] | cmd_1h[OP_NEG_A]);
    ctl.cin      = ~ctl.pass | cmd_1h[OP_INC_A] | cmd_1h[OP_INC_B];
  end
endmodule

// File: rtl/addfe_swap.sv
module addfe_swap #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         straight,
  output logic [W-1:0] lane1,
  output logic [W-1:0] lane2
);
  assign lane1 = straight ? a_in : b_in;
  assign lane2 = straight ? b_in : a_in;
endmodule

// File: rtl/addfe_route.sv
module addfe_route #(
  parameter int W = 4
) (
  input  logic [W-1:0] lane1,
  input  logic [W-1:0] lane2,
  input  logic         keep_l1,
  input  logic         ones,
  input  logic         pass,
  output logic [W-1:0] port_x,
  output logic [W-1:0] port_y
);
  assign port_x = (lane1 & {W{keep_l1}}) | {W{ones}};
  assign port_y = pass ? lane2 : ~lane2;
endmodule

// File: rtl/addfe_ripple.sv
module addfe_ripple #(
  parameter int W = 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         c_msb,
  output logic         cout
);
  logic [W:0] c;
  assign c[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_fa
    assign sum[i]  = x[i] ^ y[i] ^ c[i];
    assign c[i+1]  = (x[i] & y[i]) | (c[i] & (x[i] ^ y[i]));
  end

  assign c_msb = c[W-1];
  assign cout  = c[W];
endmodule

// File: rtl/addfe_shared_adder.sv
module addfe_shared_adder
  import addfe_pkg::*;
#(
  parameter int W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     a_in,
  input  logic [W-1:0]     b_in,
  input  logic [CMD_W-1:0] cmd_1h,
  output logic [W-1:0]     sum_q,
  output logic             cmsb_q,
  output logic             cout_q
);
  localparam logic [W-1:0] ALL1 = {W{1'b1}};

  addfe_ctl_t  ctl;
  logic [W-1:0] lane1, lane2, port_x, port_y, sum_d;
  logic         cmsb_d, cout_d;

  addfe_ctl u_ctl (.cmd_1h(cmd_1h), .ctl(ctl));

  addfe_swap #(.W(W)) u_swap (
    .a_in(a_in), .b_in(b_in), .straight(ctl.straight),
    .lane1(lane1), .lane2(lane2)
  );

  addfe_route #(.W(W)) u_route (
    .lane1(lane1), .lane2(lane2), .keep_l1(ctl.keep_l1),
    .ones(ctl.ones), .pass(ctl.pass), .port_x(port_x), .port_y(port_y)
  );

  addfe_ripple #(.W(W)) u_add (
    .x(port_x), .y(port_y), .cin(ctl.cin),
    .sum(sum_d), .c_msb(cmsb_d), .cout(cout_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q  <= '0;
      cmsb_q <= 1'b0;
      cout_q <= 1'b0;
    end else begin
      sum_q  <= sum_d;
      cmsb_q <= cmsb_d;
      cout_q <= cout_d;
    end
  end

  // R1: reset clears every output
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (sum_q == '0 && !cmsb_q && !cout_q));

  // R2 / R9: add with A = 0 returns B one cycle later, no carry
  assert_add_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (cmd_1h == (CMD_W'(1) << OP_ADD) && a_in == '0)
      |=> (sum_q == $past(b_in) && !cout_q));

  // R3: negating zero gives zero with a carry-out
  assert_neg_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (cmd_1h == (CMD_W'(1) << OP_NEG_A) && a_in == '0)
      |=> (sum_q == '0 && cout_q && cmsb_q));

  // R4: incrementing all ones wraps to zero with a carry-out
  assert_inc_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    (cmd_1h == (CMD_W'(1) << OP_INC_A) && a_in == ALL1)
      |=> (sum_q == '0 && cout_q));

  // R5 / R6: decrement carries out exactly when the operand is non-zero
  assert_dec_carry_R5: assert property (@(posedge clk) disable iff (rst)
    (cmd_1h == (CMD_W'(1) << OP_DEC_A))
      |=> (cout_q == ($past(a_in) != '0)));

  // R8: an idle command passes B with no carries
  assert_idle_b_R8: assert property (@(posedge clk) disable iff (rst)
    (cmd_1h == '0) |=> (sum_q == $past(b_in) && !cout_q && !cmsb_q));
endmodule

// File: tb/addfe_shared_adder_tb.sv
module addfe_shared_adder_tb;
  localparam int W = 4;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [W-1:0]  a_in = '0;
  logic [W-1:0]  b_in = '0;
  logic [CW-1:0] cmd_1h = '0;
  logic [W-1:0]  sum_q;
  logic          cmsb_q, cout_q;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  addfe_shared_adder #(.W(W)) u_dut (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .cmd_1h(cmd_1h),
    .sum_q(sum_q), .cmsb_q(cmsb_q), .cout_q(cout_q)
  );

  function automatic string tag_of(input int op);
    case (op)
      0, 3, 7:   return "R2";
      2, 14, 15: return "R3";
      4, 6:      return "R4";
      5, 8:      return "R5";
      default:   return "R8";
    endcase
  endfunction

  // Expected {cout, cmsb, sum}; op < 0 means an all-zero command
  function automatic logic [W+1:0] model(input int op, input logic [W-1:0] a,
                                         input logic [W-1:0] b);
    logic [W-1:0] x, y;
    logic ci;
    logic [W:0] tot;
    logic [W-1:0] lo;
    x = '0; y = b; ci = 1'b0;
    case (op)
      0:  y = a;
      2:  begin x = a; y = ~b; ci = 1'b1; end
      4:  begin y = a; ci = 1'b1; end
      5:  begin x = '1; y = a; end
      6:  ci = 1'b1;
      7:  x = a;
      8:  x = '1;
      14: begin y = ~b; ci = 1'b1; end
      15: begin y = ~a; ci = 1'b1; end
      default: ;
    endcase
    tot = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
    lo  = {1'b0, x[W-2:0]} + {1'b0, y[W-2:0]} + {{(W-1){1'b0}}, ci};
    return {tot[W], lo[W-1], tot[W-1:0]};
  endfunction

  task automatic apply(input int op, input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W+1:0] exp;
    a_in = a; b_in = b;
    cmd_1h = (op < 0) ? '0 : (CW'(1) << op);
    exp = model(op, a, b);
    @(posedge clk);
    @(negedge clk);
    n_vec++;
    // R6 carry-out, R7 MSB carry, R9 one-edge latency
    if ({cout_q, cmsb_q, sum_q} !== exp) begin
      n_bad++;
      $display("FAIL %s/R6/R7/R9 op=%0d a=%0d b=%0d actual={c%0b m%0b s%0d} expected={c%0b m%0b s%0d}",
               tag_of(op), op, a, b, cout_q, cmsb_q, sum_q, exp[W+1], exp[W], exp[W-1:0]);
    end
  endtask

  task automatic t_reset_R1();
    rst = 1'b1; a_in = '1; b_in = '1; cmd_1h = CW'(1) << 7;
    @(posedge clk);
    @(negedge clk);
    n_vec++;
    if ({cout_q, cmsb_q, sum_q} !== '0) begin
      n_bad++;
      $display("FAIL R1 actual={c%0b m%0b s%0d} expected=0", cout_q, cmsb_q, sum_q);
    end
    rst = 1'b0;
  endtask

  task automatic t_sweep(input int op);
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        apply(op, W'(a), W'(b));
  endtask

  task automatic t_idle_R8();
    for (int a = 0; a < 16; a += 5)
      for (int b = 0; b < 16; b += 3) begin
        apply(-1, W'(a), W'(b));
        apply(9, W'(a), W'(b));
        apply(12, W'(a), W'(b));
      end
  endtask

  initial begin
    @(negedge clk);
    t_reset_R1();
    t_sweep(7); t_sweep(0); t_sweep(3);
    t_sweep(2); t_sweep(14); t_sweep(15);
    t_sweep(4); t_sweep(6);
    t_sweep(5); t_sweep(8);
    t_idle_R8();
    t_reset_R1();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule